// File: doc/BRIEF.md
# Guest Port I/O Trap Decision Unit

This block decides whether a guest's port input/output instruction must leave the guest and trap to the hypervisor. A request carries a 16-bit port number, an access width of one, two or four bytes, and the instruction form (plain or string, input or output). Two 4 KiB bitmap pages in memory hold one trap bit per port. The lower page covers ports 0x0000 to 0x7FFF and the upper page covers ports 0x8000 to 0xFFFF. The block fetches only the bitmap bytes it needs through a single-outstanding byte read port and then presents a verdict.

An access of N bytes at port p touches ports p through p+N-1. It traps if any of their bits is 1. Such an access spans at most two bitmap bytes, and those bytes may lie in different pages when the access straddles 0x7FFF/0x8000. An access that would run beyond port 0xFFFF traps without any fetch. The block checks both page bases for 4 KiB alignment on every request. A misaligned base yields a configuration-error verdict and no fetch.

Top module: `io_trap_check`

## Requirements
- R1: While reset is held, and after release until a request arrives, `verdict_valid`, `busy` and `mem_req` are 0.
- R2: The bit for port q is bit q[2:0] of the byte at address (q[15] ? `base_b` : `base_a`) + q[14:3]. A 1 in a touched port's bit gives `verdict_exit`=1 with `cfg_err`=0.
- R3: When every touched port's bit is 0, the verdict has `verdict_exit`=0 and `cfg_err`=0.
- R4: `req_size` 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. Only bits of ports p..p+N-1 decide the verdict, and set bits of neighbouring ports in the same byte are ignored.
- R5: `req_kind` (0 IN, 1 OUT, 2 string IN, 3 string OUT) has no effect on the verdict or on the fetches.
- R6: When p and p+N-1 lie in different bitmap bytes, the block reads the byte of p first and then the byte of p+N-1, which may be offset 0 of the upper page. The second read is skipped when the first byte already holds a set touched bit.
- R7: An access with p+N-1 > 0xFFFF (and aligned bases) gives `verdict_exit`=1, `cfg_err`=0, no memory read, with `verdict_valid` in the cycle after acceptance.
- R8: If either base has a nonzero value in bits [11:0], the verdict has `cfg_err`=1 and `verdict_exit`=1, with no memory read and `verdict_valid` in the cycle after acceptance.
- R9: A request is accepted when `req_valid` is 1 and `busy` is 0. `busy` stays 1 from the cycle after acceptance through the verdict cycle, and requests offered while busy are dropped.
- R10: `verdict_valid` is a one-cycle pulse, one per accepted request. `mem_req` is a one-cycle pulse, and a new one is issued only after `mem_rvalid` returns for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_port | input | 16 | First port of the access |
| req_size | input | 2 | Access width code |
| req_kind | input | 2 | Instruction form |
| base_a | input | 32 | Byte address of the lower bitmap page |
| base_b | input | 32 | Byte address of the upper bitmap page |
| busy | output | 1 | Lookup in progress, requests are dropped |
| mem_req | output | 1 | Bitmap byte read strobe |
| mem_addr | output | 32 | Bitmap byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 8 | Returned bitmap byte |
| verdict_valid | output | 1 | Verdict present for one cycle |
| verdict_exit | output | 1 | 1 when the access must trap |
| cfg_err | output | 1 | 1 when a base address is misaligned |

## Verification
Error and wrap verdicts are due one cycle after the accepting edge. A lookup verdict is due 1 + k·(L+1) cycles after the request is driven, where k is the expected number of byte reads and L is the memory model's return delay. The bench computes k from the bitmap contents it wrote, counts falling edges from the drive until `verdict_valid`, and compares that count with the formula. It then confirms the pulse is gone one edge later. The read count and both read addresses are compared at the verdict, after every fetch is complete, so the fetch order and the skipped second read are checked exactly.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;

  typedef enum logic [1:0] {
    KIND_IN   = 2'd0,
    KIND_OUT  = 2'd1,
    KIND_INS  = 2'd2,
    KIND_OUTS = 2'd3
  } io_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ISSUE1 = 3'd1,
    ST_WAIT1  = 3'd2,
    ST_ISSUE2 = 3'd3,
    ST_WAIT2  = 3'd4,
    ST_RESP   = 3'd5
  } trap_st_e;

  // number of extra ports beyond the first (N-1)
  function automatic logic [2:0] span_of(input logic [1:0] size_code);
    case (size_code)
      2'b00:   span_of = 3'd0;
      2'b01:   span_of = 3'd1;
      default: span_of = 3'd3;
    endcase
  endfunction

  // bits of one bitmap byte touched by an access starting at bit lo and
  // ending at bit position last (0..10, counted from the first byte)
  function automatic logic [7:0] byte_mask(input logic [2:0] lo,
                                           input logic [3:0] last,
                                           input logic       upper);
    logic [7:0] m;
    for (int j = 0; j < 8; j++) begin
      if (!upper)
        m[j] = (3'(j) >= lo) && (last[3] || (3'(j) <= last[2:0]));
      else
        m[j] = last[3] && (3'(j) <= last[2:0]);
    end
    return m;
  endfunction

endpackage

// File: rtl/io_trap_plan.sv
module io_trap_plan
  import io_trap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16
) (
  input  logic [PORT_W-1:0] port,
  input  logic [1:0]        size_code,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  output logic              misalign,
  output logic              wrap,
  output logic              need_two,
  output logic [ADDR_W-1:0] addr_first,
  output logic [ADDR_W-1:0] addr_second,
  output logic [7:0]        mask_first,
  output logic [7:0]        mask_second
);
  localparam int IDX_W     = PORT_W - 4;
  localparam int PAGE_BITS = IDX_W;

  function automatic logic [ADDR_W-1:0] byte_addr(input logic [PORT_W-1:0] q);
    logic [ADDR_W-1:0] base;
    base = q[PORT_W-1] ? base_b : base_a;
    return base + {{(ADDR_W-IDX_W){1'b0}}, q[PORT_W-2:3]};
  endfunction

  logic [2:0]        span;
  logic [PORT_W:0]   last_port;
  logic [PORT_W-1:0] end_port;
  logic [3:0]        last_bit;

  assign span      = span_of(size_code);
  assign last_port = {1'b0, port} + {{(PORT_W-2){1'b0}}, span};
  assign end_port  = last_port[PORT_W-1:0];
  assign last_bit  = {1'b0, port[2:0]} + {1'b0, span};

  assign misalign    = (|base_a[PAGE_BITS-1:0]) | (|base_b[PAGE_BITS-1:0]);
  assign wrap        = last_port[PORT_W];
  assign need_two    = port[PORT_W-1:3] != end_port[PORT_W-1:3];
  assign addr_first  = byte_addr(port);
  assign addr_second = byte_addr(end_port);
  assign mask_first  = byte_mask(port[2:0], last_bit, 1'b0);
  assign mask_second = byte_mask(port[2:0], last_bit, 1'b1);

endmodule

// File: rtl/io_trap_seq.sv
module io_trap_seq
  import io_trap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              misalign,
  input  logic              wrap,
  input  logic              need_two,
  input  logic [ADDR_W-1:0] addr_first,
  input  logic [ADDR_W-1:0] addr_second,
  input  logic [7:0]        mask_first,
  input  logic [7:0]        mask_second,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              verdict_valid,
  output logic              verdict_exit,
  output logic              cfg_err,
  output logic              byte_hit
);
  trap_st_e          state;
  logic [ADDR_W-1:0] addr1_q, addr2_q;
  logic [7:0]        mask1_q, mask2_q;
  logic              two_q, exit_q, err_q;

  assign byte_hit      = |(mem_rdata & ((state == ST_WAIT2) ? mask2_q : mask1_q));
  assign busy          = (state != ST_IDLE);
  assign mem_req       = (state == ST_ISSUE1) || (state == ST_ISSUE2);
  assign mem_addr      = (state == ST_ISSUE2) ? addr2_q : addr1_q;
  assign verdict_valid = (state == ST_RESP);
  assign verdict_exit  = exit_q;
  assign cfg_err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr1_q <= '0;
      addr2_q <= '0;
      mask1_q <= '0;
      mask2_q <= '0;
      two_q   <= 1'b0;
      exit_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          addr1_q <= addr_first;
          addr2_q <= addr_second;
          mask1_q <= mask_first;
          mask2_q <= mask_second;
          two_q   <= need_two;
          err_q   <= misalign;
          exit_q  <= misalign | wrap;
          state   <= (misalign | wrap) ? ST_RESP : ST_ISSUE1;
        end
        ST_ISSUE1: state <= ST_WAIT1;
        ST_WAIT1: if (mem_rvalid) begin
          if (byte_hit) begin
            exit_q <= 1'b1;
            state  <= ST_RESP;
          end else if (two_q) begin
            state  <= ST_ISSUE2;
          end else begin
            exit_q <= 1'b0;
            state  <= ST_RESP;
          end
        end
        ST_ISSUE2: state <= ST_WAIT2;
        ST_WAIT2: if (mem_rvalid) begin
          exit_q <= byte_hit;
          state  <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/io_trap_check.sv
module io_trap_check
  import io_trap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              verdict_valid,
  output logic              verdict_exit,
  output logic              cfg_err
);
  // named internal events, visible to the bound checker
  logic              ev_accept;
  logic              ev_hit;
  logic              misalign, wrap, need_two;
  logic [ADDR_W-1:0] addr_first, addr_second;
  logic [7:0]        mask_first, mask_second;
  logic              unused_kind;

  // the instruction form never changes the decision
  assign unused_kind = ^req_kind;
  assign ev_accept   = req_valid & ~busy;

  io_trap_plan #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_plan (
    .port        (req_port),
    .size_code   (req_size),
    .base_a      (base_a),
    .base_b      (base_b),
    .misalign    (misalign),
    .wrap        (wrap),
    .need_two    (need_two),
    .addr_first  (addr_first),
    .addr_second (addr_second),
    .mask_first  (mask_first),
    .mask_second (mask_second)
  );

  io_trap_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (ev_accept),
    .misalign      (misalign),
    .wrap          (wrap),
    .need_two      (need_two),
    .addr_first    (addr_first),
    .addr_second   (addr_second),
    .mask_first    (mask_first),
    .mask_second   (mask_second),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .verdict_valid (verdict_valid),
    .verdict_exit  (verdict_exit),
    .cfg_err       (cfg_err),
    .byte_hit      (ev_hit)
  );

endmodule

// File: rtl/io_trap_sva.sv
module io_trap_sva #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PORT_W-1:0] req_port,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] base_a,
  input logic [ADDR_W-1:0] base_b,
  input logic              busy,
  input logic              mem_req,
  input logic              verdict_valid,
  input logic              verdict_exit,
  input logic              cfg_err,
  input logic              ev_accept
);
  localparam int PAGE_BITS = PORT_W - 4;

  logic            chk_bad_base;
  logic [PORT_W:0] chk_end;
  logic [PORT_W:0] chk_add;

  assign chk_bad_base = (base_a[PAGE_BITS-1:0] != '0) || (base_b[PAGE_BITS-1:0] != '0);
  always_comb begin
    chk_add = '0;
    if (req_size == 2'b01) chk_add[0] = 1'b1;
    else if (req_size[1]) chk_add[1:0] = 2'b11;
  end
  assign chk_end = {1'b0, req_port} + chk_add;

  // R10: verdict pulse lasts one cycle
  p_verdict_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid);

  // R10: read strobe lasts one cycle
  p_read_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R9: accepted request makes the block busy
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  // R9: busy covers the verdict cycle
  p_busy_in_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> busy);

  // R8: misaligned base answers at once, trapping, without a read
  p_bad_base_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && chk_bad_base) |=> (verdict_valid && cfg_err && verdict_exit && !mem_req));

  // R7: access past the last port answers at once with exit
  p_wrap_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !chk_bad_base && chk_end[PORT_W]) |=> (verdict_valid && verdict_exit && !cfg_err && !mem_req));

  // R8: an error verdict always traps
  p_err_traps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && cfg_err) |-> verdict_exit);

endmodule

bind io_trap_check io_trap_sva #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_sva (.*);

// File: tb/tb_io_trap_check.sv
module tb_io_trap_check;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;
  localparam int BA         = 32'h0001_0000;
  localparam int BB         = 32'h0002_3000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [15:0] req_port = 0;
  logic [1:0]  req_size = 0;
  logic [1:0]  req_kind = 0;
  logic [31:0] base_a = BA;
  logic [31:0] base_b = BB;
  logic        busy, mem_req, mem_rvalid, verdict_valid, verdict_exit, cfg_err;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rdata;

  int total = 0;
  int bad   = 0;

  logic [7:0] bm [int];
  int  nreads = 0;
  int  a_first = -1, a_second = -1;
  int  pend = 0;
  int  raddr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_trap_check dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_size(req_size), .req_kind(req_kind), .base_a(base_a), .base_b(base_b),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .verdict_valid(verdict_valid),
    .verdict_exit(verdict_exit), .cfg_err(cfg_err)
  );

  function automatic logic [7:0] bm_get(input int a);
    return bm.exists(a) ? bm[a] : 8'h00;
  endfunction

  // memory model: data returns LAT falling edges after the strobe is seen
  initial begin
    mem_rvalid = 0;
    mem_rdata  = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rvalid = 1;
          mem_rdata  = bm_get(raddr);
        end
      end
      if (mem_req) begin
        raddr = int'(mem_addr);
        pend  = LAT;
        if (nreads == 0) a_first = raddr; else a_second = raddr;
        nreads++;
      end
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int port_byte(input int q);
    return ((q >= 32768) ? int'(base_b) : int'(base_a)) + ((q & 32767) >> 3);
  endfunction

  function automatic int port_bit(input int q);
    return (bm_get(port_byte(q)) >> (q % 8)) & 1;
  endfunction

  // one request, checked against values computed from the bitmap contents
  task automatic run_req(input int port, input int sz, input int kind, input string rq);
    int n, e_exit, e_err, e_reads, e_a1, e_a2, cnt, hit1, hit2;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    e_err = ((base_a & 32'hFFF) != 0 || (base_b & 32'hFFF) != 0) ? 1 : 0;
    e_a1 = port_byte(port);
    e_a2 = port_byte(port + n - 1);
    if (e_err) begin e_exit = 1; e_reads = 0; end
    else if (port + n - 1 > 65535) begin e_exit = 1; e_reads = 0; end
    else begin
      hit1 = 0; hit2 = 0;
      for (int q = port; q < port + n; q++) begin
        if ((q >> 3) == (port >> 3)) hit1 |= port_bit(q);
        else hit2 |= port_bit(q);
      end
      if (hit1) begin e_exit = 1; e_reads = 1; end
      else if (((port + n - 1) >> 3) != (port >> 3)) begin e_exit = hit2; e_reads = 2; end
      else begin e_exit = 0; e_reads = 1; end
    end
    @(negedge clk);
    nreads = 0; a_first = -1; a_second = -1;
    req_port = 16'(port); req_size = 2'(sz); req_kind = 2'(kind); req_valid = 1;
    cnt = 0;
    do begin
      @(negedge clk);
      req_valid = 0;
      cnt++;
      if (cnt == 1) chk("R9", {rq, " busy after accept"}, busy, 1);
    end while (!verdict_valid && cnt < 60);
    chk(rq, "latency", cnt, 1 + e_reads * (LAT + 1));
    chk(rq, "exit", verdict_exit, e_exit);
    chk(rq, "cfg_err", cfg_err, e_err);
    chk(rq, "reads", nreads, e_reads);
    if (e_reads >= 1) chk(rq, "first addr", a_first, e_a1);
    if (e_reads == 2) chk(rq, "second addr", a_second, e_a2);
    @(negedge clk);
    chk("R10", {rq, " pulse ended"}, verdict_valid, 0);
    chk("R9", {rq, " idle after verdict"}, busy, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "valid in reset", verdict_valid, 0);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "mem_req in reset", mem_req, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", "valid after reset", verdict_valid, 0);
    chk("R1", "busy after reset", busy, 0);
  endtask

  task automatic t_single_bits;
    bm[BA + 12] = 8'h81;     // ports 0x60 and 0x67
    bm[BB + 30] = 8'h08;     // port 0x80F3
    run_req(16'h0060, 0, 0, "R2 lower map hit");
    run_req(16'h0061, 0, 0, "R3 clear bit");
    run_req(16'h80F3, 0, 1, "R2 upper map hit");
    run_req(16'h00F3, 0, 1, "R3 same offset lower map clear");
  endtask

  task automatic t_kinds;
    for (int k = 0; k < 4; k++) begin
      run_req(16'h0060, 0, k, "R5 kind trap");
      run_req(16'h0062, 0, k, "R5 kind pass");
    end
  endtask

  task automatic t_widths;
    run_req(16'h0066, 0, 0, "R4 one byte neighbour set");
    run_req(16'h0066, 1, 0, "R4 two bytes reach set bit");
    run_req(16'h0062, 2, 0, "R4 four bytes between set bits");
    run_req(16'h0062, 3, 0, "R4 size code 3 as four");
    run_req(16'h0064, 3, 0, "R4 size code 3 reaches bit 7");
  endtask

  task automatic t_cross;
    bm[BA + 14] = 8'h02;     // port 0x71
    run_req(16'h006E, 2, 0, "R6 second byte hit");
    run_req(16'h007F, 1, 0, "R6 two clear bytes");
    bm[BB] = 8'h02;          // port 0x8001
    run_req(16'h7FFE, 2, 2, "R6 lower to upper map");
    bm[BA + 13] = 8'h80;     // port 0x6F
    run_req(16'h006F, 1, 3, "R6 skip second read");
  endtask

  task automatic t_wrap;
    run_req(16'hFFFF, 1, 0, "R7 two bytes past end");
    run_req(16'hFFFD, 2, 1, "R7 four bytes past end");
    run_req(16'hFFFF, 0, 0, "R7 last port no wrap");
    run_req(16'hFFFC, 2, 0, "R7 four bytes at end");
  endtask

  task automatic t_misalign;
    base_a = BA + 32'h10;
    run_req(16'h0060, 0, 0, "R8 lower base misaligned");
    base_a = BA;
    base_b = BB + 32'h800;
    run_req(16'h0061, 0, 0, "R8 upper base misaligned");
    run_req(16'hFFFF, 1, 0, "R8 error before wrap");
    base_b = BB;
    run_req(16'h0061, 0, 0, "R8 restored bases");
  endtask

  task automatic t_busy_drop;
    int verdicts = 0;
    @(negedge clk);
    nreads = 0; a_first = -1; a_second = -1;
    req_port = 16'h0060; req_size = 0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    req_port = 16'h8001; req_size = 0; req_valid = 1;   // offered while busy
    chk("R9", "busy while second offered", busy, 1);
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 15; i++) begin
      if (verdict_valid) begin
        verdicts++;
        chk("R9", "kept request verdict", verdict_exit, 1);
      end
      @(negedge clk);
    end
    chk("R10", "one verdict per accepted request", verdicts, 1);
    chk("R9", "dropped request not read", nreads, 1);
    chk("R9", "read address of kept request", a_first, BA + 12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single_bits();
    t_kinds();
    t_widths();
    t_cross();
    t_wrap();
    t_misalign();
    t_busy_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule